// File: doc/BRIEF.md
# Asynchronous SRAM Pin Timing Monitor

This block observes the pins of an asynchronous byte-wide static RAM bus and reports protocol and timing rule breaches. It never drives the bus: it latches the active-low chip select, output enable and write strobe, the address, the data presented by the controller, and a flag that tells whether the controller currently drives the data lines. Intervals are measured in whole sample clocks. Each nanosecond minimum from the memory's timing table is converted to a sample count at elaboration, so the same block serves any sample rate.

A write lasts while chip select and write strobe are both low. Whichever of the two rises first ends it. Data setup, data hold and the select-to-end span are all measured against that ending edge. The block also recomputes, from the pins, when the memory itself drives the data lines. If the controller drives them in the same sample, the block reports contention.

Every rule has a one-sample pulse output and a sticky flag. The sticky flag stays set until a synchronous clear. Two counters tally finished writes and finished reads, for use as a coarse activity measure.

Top module: `sram_timing_mon`

## Requirements
- R1: After reset, err_o, err_pulse_o, wr_count_o and rd_count_o are all zero.
- R2: Bit 0 (setup) pulses when a write ends and the data had been unchanged for fewer than ceil(DW_NS/SAMPLE_NS) samples (3 by default) before the ending sample.
- R3: Bit 1 (hold) pulses when the data changes on the sample where a write ends, or within ceil(DH_NS/SAMPLE_NS) samples after it (0 by default, so only the ending sample counts).
- R4: Bit 2 (address) pulses when the address differs between two consecutive samples in both of which the write strobe is low, whatever the chip select does.
- R5: Bit 3 (strobe width) pulses when the write strobe rises to end a write after being low for fewer than ceil(WP_NS/SAMPLE_NS) samples (5 by default).
- R6: Bit 4 (select span) pulses when a write ends and chip select had been low for fewer than ceil(CW_NS/SAMPLE_NS) samples (7 by default).
- R7: Bit 5 (contention) pulses for each sample in which chip select and output enable are low, the write strobe is high and the controller drives the bus. No pulse occurs while the write strobe is low, including when chip select falls together with it or after it.
- R8: Every pulse appears exactly two clocks after the pins are presented to the inputs and lasts one clock. The matching err_o bit is set in the same clock and stays set until clear_i. If a new breach lands in the clearing clock, the bit stays set.
- R9: wr_count_o increments by one for each write end, whether chip select or write strobe ends it. It wraps at 2^CNT_W.
- R10: rd_count_o increments by one when, after a read sample (select low, strobe high, output enable low), chip select rises or the address changes.
- R11: Interval counters saturate. A write that lasts far longer than the counter range, with data held constant, reports no setup, width or span breach.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | Synchronous clear of the sticky flags |
| ce_ni | input | 1 | Chip select pin, active low |
| oe_ni | input | 1 | Output enable pin, active low |
| we_ni | input | 1 | Write strobe pin, active low |
| addr_i | input | ADDR_W | Address pins |
| data_i | input | DATA_W | Data pins as driven by the controller |
| host_drive_i | input | 1 | Controller drives the data pins |
| err_o | output | 6 | Sticky breach flags, one bit per rule |
| err_pulse_o | output | 6 | One-clock breach pulses, one bit per rule |
| wr_count_o | output | CNT_W | Completed writes |
| rd_count_o | output | CNT_W | Completed reads |

## Verification
The hardest case to reach is a write that runs longer than the interval counter range. Only saturation separates a correct result from a false setup, width and span breach, and random traffic never holds a strobe low for hundreds of samples. A directed write of 258 samples forces it. A wrapping 8-bit counter would read 2 at that point.

Both strobe orders are driven directly. One write is ended by chip select while the strobe is still low. Another has select and strobe falling in the same sample with the output enabled and the controller driving, which must produce no contention. Random transactions with short pulses, late data and glitches then mix the rules, and a sample-history model in the bench predicts every pulse.

// File: rtl/sram_mon_pkg.sv
package sram_mon_pkg;
  localparam int unsigned NUM_RULES     = 6;
  localparam int unsigned RULE_SETUP    = 0;
  localparam int unsigned RULE_HOLD     = 1;
  localparam int unsigned RULE_ADDR     = 2;
  localparam int unsigned RULE_WPULSE   = 3;
  localparam int unsigned RULE_CWIDTH   = 4;
  localparam int unsigned RULE_CONTEND  = 5;

  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned per);
    return (ns + per - 1) / per;
  endfunction
endpackage

// File: rtl/sram_pin_sampler.sv
module sram_pin_sampler #(
  parameter int unsigned   W       = 8,
  parameter logic [W-1:0]  RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] pins_i,
  output logic [W-1:0] cur_o,
  output logic [W-1:0] prv_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_o <= RST_VAL;
      prv_o <= RST_VAL;
    end else begin
      cur_o <= pins_i;
      prv_o <= cur_o;
    end
  end
endmodule

// File: rtl/sram_run_counter.sv
module sram_run_counter #(
  parameter int unsigned  W         = 8,
  parameter logic [W-1:0] START_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         restart_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_o <= '0;
    else if (restart_i)       cnt_o <= START_VAL;
    else if (cnt_o != '1)     cnt_o <= cnt_o + 1'b1;  // saturate
  end
endmodule

// File: rtl/sram_rule_eval.sv
module sram_rule_eval import sram_mon_pkg::*; #(
  parameter int unsigned AW        = 15,
  parameter int unsigned DW        = 8,
  parameter int unsigned RW        = 8,
  parameter int unsigned SETUP_CYC = 3,
  parameter int unsigned HOLD_CYC  = 0,
  parameter int unsigned WP_CYC    = 5,
  parameter int unsigned CW_CYC    = 7,
  localparam int unsigned PW       = AW + DW + 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [PW-1:0]        cur_i,
  input  logic [PW-1:0]        prv_i,
  input  logic                 data_chg_i,
  input  logic [RW-1:0]        data_run_i,
  input  logic [RW-1:0]        we_run_i,
  input  logic [RW-1:0]        ce_run_i,
  output logic [NUM_RULES-1:0] hit_o,
  output logic                 wr_end_o,
  output logic                 rd_done_o
);
  localparam int unsigned DRV_B = AW + DW;
  localparam int unsigned WE_B  = DRV_B + 1;
  localparam int unsigned OE_B  = DRV_B + 2;
  localparam int unsigned CE_B  = DRV_B + 3;
  localparam int unsigned HLW   = $clog2(HOLD_CYC + 2);

  logic c_ce_n, c_oe_n, c_we_n, c_drv, p_ce_n, p_oe_n, p_we_n;
  logic wr_act_c, wr_act_p, addr_chg, we_rise;
  logic [HLW-1:0] hold_left_q;
  logic unused_prv_drv;

  assign c_ce_n = cur_i[CE_B];
  assign c_oe_n = cur_i[OE_B];
  assign c_we_n = cur_i[WE_B];
  assign c_drv  = cur_i[DRV_B];
  assign p_ce_n = prv_i[CE_B];
  assign p_oe_n = prv_i[OE_B];
  assign p_we_n = prv_i[WE_B];
  assign unused_prv_drv = prv_i[DRV_B];

  assign addr_chg = cur_i[DRV_B-1:DW] != prv_i[DRV_B-1:DW];
  assign wr_act_c = !c_ce_n && !c_we_n;
  assign wr_act_p = !p_ce_n && !p_we_n;
  assign wr_end_o = wr_act_p && !wr_act_c;
  assign we_rise  = wr_act_p && c_we_n;

  // hold window after the terminating edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 hold_left_q <= '0;
    else if (wr_end_o)           hold_left_q <= HLW'(HOLD_CYC);
    else if (hold_left_q != '0)  hold_left_q <= hold_left_q - 1'b1;
  end

  always_comb begin
    hit_o               = '0;
    hit_o[RULE_SETUP]   = wr_end_o && (data_run_i < RW'(SETUP_CYC));
    hit_o[RULE_HOLD]    = data_chg_i && (wr_end_o || hold_left_q != '0);
    hit_o[RULE_ADDR]    = !c_we_n && !p_we_n && addr_chg;
    hit_o[RULE_WPULSE]  = we_rise && (we_run_i < RW'(WP_CYC));
    hit_o[RULE_CWIDTH]  = wr_end_o && (ce_run_i < RW'(CW_CYC));
    hit_o[RULE_CONTEND] = !c_ce_n && c_we_n && !c_oe_n && c_drv;
  end

  assign rd_done_o = !p_ce_n && p_we_n && !p_oe_n && (c_ce_n || addr_chg);
endmodule

// File: rtl/sram_err_bank.sv
module sram_err_bank #(
  parameter int unsigned NR = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic [NR-1:0] hit_i,
  output logic [NR-1:0] sticky_o,
  output logic [NR-1:0] pulse_o
);
  for (genvar g = 0; g < NR; g++) begin : g_rule
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sticky_o[g] <= 1'b0;
        pulse_o[g]  <= 1'b0;
      end else begin
        pulse_o[g]  <= hit_i[g];
        sticky_o[g] <= (sticky_o[g] && !clear_i) || hit_i[g];  // set wins
      end
    end
  end
endmodule

// File: rtl/sram_timing_mon.sv
module sram_timing_mon import sram_mon_pkg::*; #(
  parameter int unsigned ADDR_W    = 15,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned RUN_W     = 8,
  parameter int unsigned SAMPLE_NS = 10,
  parameter int unsigned DW_NS     = 30,
  parameter int unsigned DH_NS     = 0,
  parameter int unsigned WP_NS     = 50,
  parameter int unsigned CW_NS     = 70
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 clear_i,
  input  logic                 ce_ni,
  input  logic                 oe_ni,
  input  logic                 we_ni,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [DATA_W-1:0]    data_i,
  input  logic                 host_drive_i,
  output logic [NUM_RULES-1:0] err_o,
  output logic [NUM_RULES-1:0] err_pulse_o,
  output logic [CNT_W-1:0]     wr_count_o,
  output logic [CNT_W-1:0]     rd_count_o
);
  localparam int unsigned SETUP_CYC = ns_to_cyc(DW_NS, SAMPLE_NS);
  localparam int unsigned HOLD_CYC  = ns_to_cyc(DH_NS, SAMPLE_NS);
  localparam int unsigned WP_CYC    = ns_to_cyc(WP_NS, SAMPLE_NS);
  localparam int unsigned CW_CYC    = ns_to_cyc(CW_NS, SAMPLE_NS);
  localparam int unsigned PW        = ADDR_W + DATA_W + 4;
  localparam int unsigned WE_B      = ADDR_W + DATA_W + 1;
  localparam int unsigned CE_B      = ADDR_W + DATA_W + 3;
  localparam logic [PW-1:0] PIN_IDLE = {3'b111, {(PW-3){1'b0}}};

  logic [PW-1:0]        pins, cur, prv;
  logic [RUN_W-1:0]     data_run, we_run, ce_run;
  logic [NUM_RULES-1:0] hit;
  logic                 data_chg, wr_end, rd_done;

  assign pins     = {ce_ni, oe_ni, we_ni, host_drive_i, addr_i, data_i};
  assign data_chg = cur[DATA_W-1:0] != prv[DATA_W-1:0];

  sram_pin_sampler #(.W(PW), .RST_VAL(PIN_IDLE)) u_sampler (
    .clk_i, .rst_ni, .pins_i(pins), .cur_o(cur), .prv_o(prv)
  );

  sram_run_counter #(.W(RUN_W), .START_VAL(RUN_W'(1))) u_data_run (
    .clk_i, .rst_ni, .restart_i(data_chg), .cnt_o(data_run)
  );
  sram_run_counter #(.W(RUN_W), .START_VAL('0)) u_we_run (
    .clk_i, .rst_ni, .restart_i(cur[WE_B]), .cnt_o(we_run)
  );
  sram_run_counter #(.W(RUN_W), .START_VAL('0)) u_ce_run (
    .clk_i, .rst_ni, .restart_i(cur[CE_B]), .cnt_o(ce_run)
  );

  sram_rule_eval #(
    .AW(ADDR_W), .DW(DATA_W), .RW(RUN_W), .SETUP_CYC(SETUP_CYC),
    .HOLD_CYC(HOLD_CYC), .WP_CYC(WP_CYC), .CW_CYC(CW_CYC)
  ) u_rules (
    .clk_i, .rst_ni, .cur_i(cur), .prv_i(prv), .data_chg_i(data_chg),
    .data_run_i(data_run), .we_run_i(we_run), .ce_run_i(ce_run),
    .hit_o(hit), .wr_end_o(wr_end), .rd_done_o(rd_done)
  );

  sram_err_bank #(.NR(NUM_RULES)) u_errs (
    .clk_i, .rst_ni, .clear_i, .hit_i(hit), .sticky_o(err_o), .pulse_o(err_pulse_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_count_o <= '0;
      rd_count_o <= '0;
    end else begin
      if (wr_end)  wr_count_o <= wr_count_o + 1'b1;
      if (rd_done) rd_count_o <= rd_count_o + 1'b1;
    end
  end
endmodule

// File: rtl/sram_timing_mon_chk.sv
module sram_timing_mon_chk import sram_mon_pkg::*; #(
  parameter int unsigned NR    = 6,
  parameter int unsigned CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             clear_i,
  input logic             ce_ni,
  input logic             we_ni,
  input logic [NR-1:0]    err_o,
  input logic [NR-1:0]    err_pulse_o,
  input logic [CNT_W-1:0] wr_count_o,
  input logic [CNT_W-1:0] rd_count_o
);
  logic [1:0] warm_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             warm_q <= '0;
    else if (warm_q != 2'd3) warm_q <= warm_q + 1'b1;
  end

  assert_pulse_sets_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_pulse_o & ~err_o) == '0);

  assert_sticky_holds_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_q != 2'd0 && !clear_i) |=> (($past(err_o) & ~err_o) == '0));

  assert_wr_count_step_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_q == 2'd3 && wr_count_o != $past(wr_count_o)) |->
      (wr_count_o == $past(wr_count_o) + 1'b1) && ($past(ce_ni, 2) || $past(we_ni, 2)));

  assert_rd_count_step_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_q == 2'd3 && rd_count_o != $past(rd_count_o)) |->
      (rd_count_o == $past(rd_count_o) + 1'b1) && $past(we_ni, 3) && !$past(ce_ni, 3));

  assert_contend_needs_read_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_q == 2'd3 && err_pulse_o[RULE_CONTEND]) |-> (!$past(ce_ni, 2) && $past(we_ni, 2)));

  assert_addr_needs_we_low_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_q == 2'd3 && err_pulse_o[RULE_ADDR]) |-> (!$past(we_ni, 2) && !$past(we_ni, 3)));

  assert_wpulse_on_rise_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_q == 2'd3 && err_pulse_o[RULE_WPULSE]) |-> ($past(we_ni, 2) && !$past(we_ni, 3)));
endmodule

bind sram_timing_mon sram_timing_mon_chk #(.NR(sram_mon_pkg::NUM_RULES), .CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(clear_i), .ce_ni(ce_ni), .we_ni(we_ni),
  .err_o(err_o), .err_pulse_o(err_pulse_o), .wr_count_o(wr_count_o), .rd_count_o(rd_count_o)
);

// File: tb/sram_timing_mon_tb.sv
module sram_timing_mon_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 15;
  localparam int DW = 8;
  localparam int NR = 6;
  localparam int SETUP_CYC = 3;  // 30 ns at 10 ns samples
  localparam int HOLD_CYC  = 0;  // 0 ns
  localparam int WP_CYC    = 5;  // 50 ns
  localparam int CW_CYC    = 7;  // 70 ns

  logic clk = 1'b0, rst_n = 1'b0, clear = 1'b0;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, drv = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] data = '0;
  logic [NR-1:0] err, pulse;
  logic [15:0] wr_cnt, rd_cnt;

  sram_timing_mon u_dut (
    .clk_i(clk), .rst_ni(rst_n), .clear_i(clear), .ce_ni(ce_n), .oe_ni(oe_n),
    .we_ni(we_n), .addr_i(addr), .data_i(data), .host_drive_i(drv),
    .err_o(err), .err_pulse_o(pulse), .wr_count_o(wr_cnt), .rd_count_o(rd_cnt)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct packed {
    logic ce; logic oe; logic we; logic drv;
    logic [AW-1:0] addr; logic [DW-1:0] data;
  } pin_t;
  typedef struct packed { logic [NR-1:0] hit; logic wr; logic rd; } exp_t;

  pin_t hist [16];
  exp_t pend;
  logic [NR-1:0] sticky_x;
  logic [15:0] wr_x, rd_x;
  int checks = 0, fails = 0;

  function automatic pin_t idle_pin(input logic [AW-1:0] a);
    pin_t p;
    p.ce = 1'b1; p.oe = 1'b1; p.we = 1'b1; p.drv = 1'b0; p.addr = a; p.data = '0;
    return p;
  endfunction

  function automatic bit is_wr(input pin_t p);
    return !p.ce && !p.we;
  endfunction

  function automatic bit wr_end_at(input int j);
    return is_wr(hist[j+1]) && !is_wr(hist[j]);
  endfunction

  // samples before the current one, newest first
  function automatic int run_len(input int kind);
    int n = 0;
    for (int k = 1; k < 16; k++) begin
      bit ok;
      case (kind)
        0:       ok = (hist[k].data == hist[1].data);
        1:       ok = !hist[k].we;
        default: ok = !hist[k].ce;
      endcase
      if (!ok) break;
      n++;
    end
    return n;
  endfunction

  function automatic exp_t model();
    exp_t e;
    pin_t c = hist[0];
    pin_t p = hist[1];
    bit hold_win = 1'b0;
    for (int j = 0; j <= HOLD_CYC; j++) if (wr_end_at(j)) hold_win = 1'b1;
    e.hit    = '0;
    e.hit[0] = wr_end_at(0) && run_len(0) < SETUP_CYC;
    e.hit[1] = (c.data != p.data) && hold_win;
    e.hit[2] = !c.we && !p.we && (c.addr != p.addr);
    e.hit[3] = is_wr(p) && c.we && run_len(1) < WP_CYC;
    e.hit[4] = wr_end_at(0) && run_len(2) < CW_CYC;
    e.hit[5] = !c.ce && c.we && !c.oe && c.drv;
    e.wr     = wr_end_at(0);
    e.rd     = !p.ce && p.we && !p.oe && (c.ce || c.addr != p.addr);
    return e;
  endfunction

  function automatic string rule_req(input int i);
    case (i)
      0: return "R2 setup";
      1: return "R3 hold";
      2: return "R4 address";
      3: return "R5 strobe width";
      4: return "R6 select span";
      default: return "R7 contention";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(input pin_t p, input bit clr);
    exp_t nxt;
    ce_n = p.ce; oe_n = p.oe; we_n = p.we; drv = p.drv; addr = p.addr; data = p.data;
    clear = clr;
    for (int k = 15; k > 0; k--) hist[k] = hist[k-1];
    hist[0] = p;
    nxt = model();
    @(negedge clk);
    sticky_x = (clr ? '0 : sticky_x) | pend.hit;
    wr_x = wr_x + 16'(pend.wr);
    rd_x = rd_x + 16'(pend.rd);
    for (int i = 0; i < NR; i++)
      check(pulse[i] == pend.hit[i], rule_req(i), 32'(pulse[i]), 32'(pend.hit[i]));
    check(err == sticky_x, "R8 sticky", 32'(err), 32'(sticky_x));
    check(wr_cnt == wr_x, "R9 write count", 32'(wr_cnt), 32'(wr_x));
    check(rd_cnt == rd_x, "R10 read count", 32'(rd_cnt), 32'(rd_x));
    pend = nxt;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(idle_pin(hist[0].addr), 1'b0);
  endtask

  task automatic clear_all();
    step(idle_pin(hist[0].addr), 1'b1);
    idle(2);
  endtask

  task automatic expect_err(input logic [NR-1:0] mask, input string req);
    idle(2);
    check(err == mask, req, 32'(err), 32'(mask));
  endtask

  task automatic wr_txn(input logic [AW-1:0] a, input logic [DW-1:0] d, input int lead,
                        input int wlen, input int d_late, input bit end_ce,
                        input bit a_glitch, input bit h_glitch, input bit oe_on);
    pin_t p = idle_pin(a);
    p.data = (d_late > wlen) ? d : ~d;
    p.oe = !oe_on;
    p.ce = 1'b0;
    for (int i = 0; i < lead; i++) step(p, 1'b0);
    p.we = 1'b0; p.drv = 1'b1;
    for (int i = 0; i < wlen; i++) begin
      if (i >= wlen - d_late) p.data = d;
      if (a_glitch && i == wlen / 2 && i > 0) p.addr = a ^ AW'(1);
      step(p, 1'b0);
    end
    if (h_glitch) p.data = ~d;
    if (end_ce) begin
      p.ce = 1'b1; step(p, 1'b0);
      p.we = 1'b1; p.drv = 1'b0; step(p, 1'b0);
    end else begin
      p.we = 1'b1; p.drv = 1'b0; step(p, 1'b0);
      p.ce = 1'b1; step(p, 1'b0);
    end
    p.oe = 1'b1;
    step(p, 1'b0);
  endtask

  task automatic rd_txn(input logic [AW-1:0] a, input int beats, input int blen, input bit bad);
    pin_t p = idle_pin(a);
    p.ce = 1'b0; p.oe = 1'b0;
    for (int b = 0; b < beats; b++) begin
      p.addr = a + AW'(b);
      p.drv = bad && (b == 0);
      for (int i = 0; i < blen; i++) step(p, 1'b0);
    end
    step(idle_pin(p.addr), 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual running expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] rd0, wr0;
    void'($urandom(32'd20240));
    for (int k = 0; k < 16; k++) hist[k] = idle_pin('0);
    pend = '0; sticky_x = '0; wr_x = '0; rd_x = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check(err == '0 && pulse == '0, "R1 flags after reset", 32'({err, pulse}), 32'(0));
    check(wr_cnt == '0 && rd_cnt == '0, "R1 counts after reset", 32'({wr_cnt, rd_cnt}), 32'(0));
    idle(10);

    // clean writes, strobe-ended and select-ended
    wr_txn(15'h0123, 8'h5a, 1, 6, 6, 1'b0, 1'b0, 1'b0, 1'b0);
    wr_txn(15'h0124, 8'ha5, 0, 7, 7, 1'b1, 1'b0, 1'b0, 1'b0);
    expect_err('0, "R9 clean writes flag nothing");
    check(wr_cnt == 16'd2, "R9 two writes counted", 32'(wr_cnt), 32'd2);

    wr_txn(15'h0200, 8'h11, 2, 6, 2, 1'b0, 1'b0, 1'b0, 1'b0);
    expect_err(6'b000001, "R2 late data");
    clear_all();
    check(err == '0, "R8 clear", 32'(err), 32'(0));

    wr_txn(15'h0201, 8'h22, 2, 6, 6, 1'b0, 1'b0, 1'b1, 1'b0);
    expect_err(6'b000010, "R3 data moves on ending sample");
    clear_all();

    wr_txn(15'h0202, 8'h33, 2, 6, 6, 1'b0, 1'b1, 1'b0, 1'b0);
    expect_err(6'b000100, "R4 address moves under strobe");
    clear_all();

    wr_txn(15'h0203, 8'h44, 5, 3, 3, 1'b0, 1'b0, 1'b0, 1'b0);
    expect_err(6'b001000, "R5 short strobe");
    clear_all();

    wr_txn(15'h0204, 8'h55, 0, 6, 6, 1'b0, 1'b0, 1'b0, 1'b0);
    expect_err(6'b010000, "R6 short select span");
    clear_all();

    // select and strobe fall together with output enabled and controller driving
    wr_txn(15'h0205, 8'h66, 0, 7, 7, 1'b0, 1'b0, 1'b0, 1'b1);
    expect_err('0, "R7 no contention while strobe low");

    rd0 = rd_cnt;
    rd_txn(15'h0300, 3, 2, 1'b1);
    expect_err(6'b100000, "R7 controller drives during read");
    check(rd_cnt - rd0 == 16'd3, "R10 three reads", 32'(rd_cnt - rd0), 32'd3);

    // breach in the clearing clock keeps the bit
    clear_all();
    begin
      pin_t p = idle_pin(15'h0301);
      p.ce = 1'b0; p.oe = 1'b0; p.drv = 1'b1;
      step(p, 1'b0);
      step(idle_pin(15'h0301), 1'b1);
    end
    idle(1);
    check(err[5] == 1'b1, "R8 set wins over clear", 32'(err[5]), 32'd1);
    clear_all();

    wr0 = wr_cnt;
    wr_txn(15'h0400, 8'h77, 0, 258, 258, 1'b0, 1'b0, 1'b0, 1'b0);
    expect_err('0, "R11 long write saturates");
    check(wr_cnt - wr0 == 16'd1, "R9 long write counted", 32'(wr_cnt - wr0), 32'd1);

    for (int t = 0; t < 300; t++) begin
      int op = $urandom % 3;
      if (op == 0)
        wr_txn(AW'($urandom), DW'($urandom), $urandom % 3, 2 + $urandom % 7, 1 + $urandom % 7,
               1'($urandom % 2), ($urandom % 8) == 0, ($urandom % 8) == 0, 1'($urandom % 2));
      else if (op == 1)
        rd_txn(AW'($urandom), 1 + $urandom % 4, 1 + $urandom % 3, ($urandom % 6) == 0);
      else
        idle(1 + $urandom % 3);
      if ($urandom % 8 == 0) step(idle_pin(hist[0].addr), 1'b1);
    end
    idle(3);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule